// File: doc/BRIEF.md
# Interrupt Routing Table Register Window

This block is the software-facing register file of an interrupt routing controller. Software reaches it through two offsets: an index register that names an internal register, and a 32-bit data window through which that register is read or written. Behind the window sit an identification register and a fixed capability register. An alias of the identification register sits at a third index. A table of routing entries follows them. Each entry is 64 bits wide and is reached as two 32-bit halves.

Each routing entry carries a vector, delivery and destination fields, a trigger-mode bit and a mask bit. It also holds two status bits owned by the interrupt dispatcher: delivery status and remote-IRR. Software writes cannot change those two bits. When a write leaves an entry edge-triggered, its remote-IRR is forced to zero. Every entry write raises a one-cycle rescan strobe towards the dispatcher. A write to the end-of-interrupt offset is forwarded as a strobe carrying the vector, but only for the newer revision. The whole table is presented in parallel to the dispatcher.

Top module: `irq_route_window`

## Requirements
- R1: Only offsets 0x00 (index), 0x10 (window) and 0x40 (end-of-interrupt) respond. Every other offset reads 0 and ignores writes.
- R2: The 8-bit index register accepts writes at offset 0x00 of any size from wdata[7:0]. It reads back zero-extended.
- R3: Index 0 and index 2 both read the 4-bit ID in bits 27:24. A window write at index 0 loads the ID from wdata[27:24]. A write at index 2 changes nothing.
- R4: Index 1 reads the revision parameter in bits 7:0 and (entry count - 1) in bits 23:16, with zeros elsewhere. Writes to it change nothing.
- R5: Index 0x10+2k reaches bits 31:0 of entry k, and index 0x11+2k reaches bits 63:32 of entry k, for k below the entry count. A write replaces only that half.
- R6: Indices 3 to 0x0F, and indices at or past 0x10 + 2 x entry count, read 0 and ignore writes.
- R7: Window reads and writes whose size is not 4 bytes (size code 4) are ignored. Such reads return 0.
- R8: Entry bit 12 (delivery status) and bit 14 (remote-IRR) are never taken from software data. Bit 12 follows hw_dstat one cycle later. Bit 14 is set by hw_rirr_set, or else cleared by hw_rirr_clr.
- R9: After any entry write that leaves bit 15 (trigger mode) at 0, meaning edge, bit 14 of that entry is 0. This holds even when the dispatcher sets it in the same cycle.
- R10: In the cycle after an entry write, rescan_pulse is high and rescan_idx gives the entry number. Otherwise rescan_pulse is low.
- R11: A 4-byte write to offset 0x40 raises eoi_pulse for one cycle, with eoi_vec equal to wdata[7:0]. This happens only when the revision is 0x20. The revision parameter may only be 0x11 or 0x20.
- R12: rd_data is 0 when there is no read request. After reset, every entry reads 0x0000_0000_0001_0000 (mask bit 16 set), and the index, the ID and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational in the request cycle |
| hw_rirr_set | input | NPINS | Dispatcher sets remote-IRR per entry |
| hw_rirr_clr | input | NPINS | Dispatcher clears remote-IRR per entry |
| hw_dstat | input | NPINS | Delivery status level per entry |
| tbl_flat | output | NPINS*64 | All entries, entry k at bits 64k+63:64k |
| rescan_pulse | output | 1 | Entry written in the previous cycle |
| rescan_idx | output | $clog2(NPINS) | Entry that was written |
| eoi_pulse | output | 1 | End-of-interrupt write seen |
| eoi_vec | output | 8 | Vector of that end-of-interrupt |

## Verification
The hardest case to reach from the ports is a software write and a dispatcher update landing on the same entry in the same cycle. The write must keep the dispatcher's new status bits, yet still zero remote-IRR if the entry ends up edge-triggered. The stimulus sets up that collision on purpose: it drives hw_rirr_set into an entry in the very cycle that a window write turns the entry edge-triggered. It also does the reverse, with a level-triggered entry. A long run of random accesses follows, with random dispatcher activity, so that such collisions recur at every index, half and size. A behavioural model checks the whole table on every clock.

// File: rtl/irw_pkg.sv
// Shared constants and types for the interrupt routing table window.
// Assumes 64-bit entries, whose control-bit positions are decoded by the dispatcher.
package irw_pkg;
    localparam int ENT_W  = 64;
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [7:0] SEL_TBL = 8'h10;

    localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << B_MASK;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENT
    } tgt_e;
endpackage

// File: rtl/irw_decode.sv
// Index decoder: turns the index register value into a target register,
// an entry number and a half select.
// Assumes 0x10 + 2*NPINS <= 256, so that every entry index fits in 8 bits.
module irw_decode
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic [7:0]       sel,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    logic [7:0] off;

    // Classify the index and work out the entry position.
    always_comb begin
        off = sel - SEL_TBL;
        tgt = TGT_NONE;
        idx = '0;
        hi  = off[0];
        if (sel == SEL_ID) begin
            tgt = TGT_ID;
        end else if (sel == SEL_VER) begin
            tgt = TGT_VER;
        end else if (sel == SEL_ARB) begin
            tgt = TGT_ARB;
        end else if (sel >= SEL_TBL && int'(off[7:1]) < NPINS) begin
            tgt = TGT_ENT;
            idx = off[IDX_W:1];
        end
    end
endmodule

// File: rtl/irw_entry.sv
// One routing entry. Software writes one 32-bit half. Delivery status and
// remote-IRR come only from the dispatcher. A write that leaves the entry
// edge-triggered clears remote-IRR.
// Assumes the hardware update and the software write are applied in the same cycle.
module irw_entry
    import irw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic             rirr_set,
    input  logic             rirr_clr,
    input  logic             dstat,
    output logic [ENT_W-1:0] ent
);
    logic [ENT_W-1:0] ent_nxt;
    logic             rirr_hw;

    // Merge the software half, the dispatcher bits and the edge rule.
    always_comb begin
        rirr_hw = rirr_set ? 1'b1 : (rirr_clr ? 1'b0 : ent[B_RIRR]);
        ent_nxt = ent;
        if (wr_en) begin
            if (wr_hi) ent_nxt[63:32] = wr_data;
            else       ent_nxt[31:0]  = wr_data;
        end
        ent_nxt[B_DSTAT] = dstat;
        ent_nxt[B_RIRR]  = rirr_hw;
        if (wr_en && !ent_nxt[B_TRIG]) ent_nxt[B_RIRR] = 1'b0;
    end

    // Entry storage; reset leaves it masked.
    always_ff @(posedge clk) begin
        if (!rst_n) ent <= ENT_RST;
        else        ent <= ent_nxt;
    end
endmodule

// File: rtl/irq_route_window.sv
// Indirect register window over an interrupt routing table.
// Holds the index register and the ID, decodes window accesses, and
// instantiates one entry per pin. Also raises the rescan and end-of-interrupt
// strobes. Assumes single-cycle requests, with read data valid combinationally.
module irq_route_window
    import irw_pkg::*;
#(
    parameter int         NPINS = 24,
    parameter logic [7:0] VER   = 8'h20,
    localparam int        IDX_W = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [7:0]             req_addr,
    input  logic [2:0]             req_size,
    input  logic [31:0]            req_wdata,
    output logic [31:0]            rd_data,
    input  logic [NPINS-1:0]       hw_rirr_set,
    input  logic [NPINS-1:0]       hw_rirr_clr,
    input  logic [NPINS-1:0]       hw_dstat,
    output logic [NPINS*ENT_W-1:0] tbl_flat,
    output logic                   rescan_pulse,
    output logic [IDX_W-1:0]       rescan_idx,
    output logic                   eoi_pulse,
    output logic [7:0]             eoi_vec
);
    localparam logic [7:0] MAXENT = 8'(NPINS - 1);
    localparam logic       EOI_OK = (VER == 8'h20);

    if (!(VER == 8'h11 || VER == 8'h20)) begin : g_bad_ver
        $error("irq_route_window: revision must be 0x11 or 0x20");
    end

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    tgt_e             tgt;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_hi;
    logic             wr, rd, word, win_wr, ent_wr;
    logic [ENT_W-1:0] ent_a [NPINS];

    irw_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
        .sel (sel_q),
        .tgt (tgt),
        .idx (dec_idx),
        .hi  (dec_hi)
    );

    // Qualify the current request.
    always_comb begin
        wr     = req_valid && req_write;
        rd     = req_valid && !req_write;
        word   = (req_size == 3'd4);
        win_wr = wr && word && (req_addr == OFF_WIN);
        ent_wr = win_wr && (tgt == TGT_ENT);
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        irw_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ent_wr && (dec_idx == IDX_W'(i))),
            .wr_hi    (dec_hi),
            .wr_data  (req_wdata),
            .rirr_set (hw_rirr_set[i]),
            .rirr_clr (hw_rirr_clr[i]),
            .dstat    (hw_dstat[i]),
            .ent      (ent_a[i])
        );
        assign tbl_flat[i*ENT_W +: ENT_W] = ent_a[i];
    end

    // Index register, ID register and the outgoing strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q        <= '0;
            id_q         <= '0;
            rescan_pulse <= 1'b0;
            rescan_idx   <= '0;
            eoi_pulse    <= 1'b0;
            eoi_vec      <= '0;
        end else begin
            if (wr && req_addr == OFF_SEL) sel_q <= req_wdata[7:0];
            if (win_wr && tgt == TGT_ID)   id_q  <= req_wdata[27:24];
            rescan_pulse <= ent_wr;
            if (ent_wr) rescan_idx <= dec_idx;
            eoi_pulse <= EOI_OK && wr && word && (req_addr == OFF_EOI);
            if (EOI_OK && wr && word && req_addr == OFF_EOI) eoi_vec <= req_wdata[7:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd) begin
            if (req_addr == OFF_SEL) begin
                rd_data = {24'h0, sel_q};
            end else if (req_addr == OFF_WIN && word) begin
                case (tgt)
                    TGT_ID, TGT_ARB: rd_data = {4'h0, id_q, 24'h0};
                    TGT_VER:         rd_data = {8'h0, MAXENT, 8'h0, VER};
                    TGT_ENT:         rd_data = dec_hi ? ent_a[dec_idx][63:32]
                                                      : ent_a[dec_idx][31:0];
                    default:         rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irw_checker.sv
// Property checker for irq_route_window, attached with bind.
// Assumes that it sees the top-level ports plus the index and ID registers.
module irw_checker
    import irw_pkg::*;
#(
    parameter int         NPINS = 24,
    parameter logic [7:0] VER   = 8'h20,
    parameter int         IDX_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [7:0]             req_addr,
    input logic [2:0]             req_size,
    input logic [31:0]            req_wdata,
    input logic [31:0]            rd_data,
    input logic [NPINS-1:0]       hw_dstat,
    input logic [NPINS*ENT_W-1:0] tbl_flat,
    input logic                   rescan_pulse,
    input logic [IDX_W-1:0]       rescan_idx,
    input logic                   eoi_pulse,
    input logic [7:0]             eoi_vec,
    input logic [7:0]             sel_q,
    input logic [3:0]             id_q
);
    logic             win_acc, ent_sel, id_wr;
    logic [ENT_W-1:0] resc_ent;

    // Recompute, from the ports, which accesses reach the window.
    always_comb begin
        win_acc  = req_valid && req_addr == OFF_WIN;
        ent_sel  = sel_q >= SEL_TBL && ((int'(sel_q) - 16) / 2) < NPINS;
        id_wr    = win_acc && req_write && req_size == 3'd4 && sel_q == SEL_ID;
        resc_ent = tbl_flat[int'(rescan_idx)*ENT_W +: ENT_W];
    end

    assert_rescan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && req_write && req_size == 3'd4 && ent_sel) |=> rescan_pulse);

    assert_edge_rirr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rescan_pulse && !resc_ent[B_TRIG]) |-> !resc_ent[B_RIRR]);

    assert_short_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && req_write && req_size != 3'd4) |=> !rescan_pulse);

    assert_short_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !req_write && req_size != 3'd4) |-> rd_data == 32'h0);

    assert_ver_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !req_write && req_size == 3'd4 && sel_q == SEL_VER)
        |-> rd_data == {8'h0, 8'(NPINS - 1), 8'h0, VER});

    assert_id_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !id_wr |=> $stable(id_q));

    assert_eoi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 3'd4 && req_addr == OFF_EOI)
        |=> (eoi_pulse == (VER == 8'h20)) && (!eoi_pulse || eoi_vec == $past(req_wdata[7:0])));

    assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> rd_data == 32'h0);

    for (genvar i = 0; i < NPINS; i++) begin : g_ds
        assert_dstat_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> tbl_flat[i*ENT_W + B_DSTAT] == $past(hw_dstat[i]));
    end
endmodule

bind irq_route_window irw_checker #(.NPINS(NPINS), .VER(VER), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_wdata    (req_wdata),
    .rd_data      (rd_data),
    .hw_dstat     (hw_dstat),
    .tbl_flat     (tbl_flat),
    .rescan_pulse (rescan_pulse),
    .rescan_idx   (rescan_idx),
    .eoi_pulse    (eoi_pulse),
    .eoi_vec      (eoi_vec),
    .sel_q        (sel_q),
    .id_q         (id_q)
);

// File: tb/irq_route_window_bench.sv
// Bench with a behavioural reference model, compared on every clock.
module irq_route_window_bench;
    localparam int         N   = 24;
    localparam logic [7:0] VER = 8'h20;
    localparam int         IW  = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]      req_addr = '0;
    logic [2:0]      req_size = '0;
    logic [31:0]     req_wdata = '0;
    logic [31:0]     rd_data;
    logic [N-1:0]    hw_rirr_set = '0, hw_rirr_clr = '0, hw_dstat = '0;
    logic [N*64-1:0] tbl_flat;
    logic            rescan_pulse, eoi_pulse;
    logic [IW-1:0]   rescan_idx;
    logic [7:0]      eoi_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state.
    logic [63:0] m_ent [N];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic        m_resc, m_eoi;
    int          m_resc_idx;
    logic [7:0]  m_eoi_vec;

    always #5 clk = ~clk;

    irq_route_window #(.NPINS(N), .VER(VER)) u_irq_route_window (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_data(rd_data), .hw_rirr_set(hw_rirr_set), .hw_rirr_clr(hw_rirr_clr),
        .hw_dstat(hw_dstat), .tbl_flat(tbl_flat), .rescan_pulse(rescan_pulse),
        .rescan_idx(rescan_idx), .eoi_pulse(eoi_pulse), .eoi_vec(eoi_vec)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic v, input logic w, input logic [7:0] a, input logic [2:0] sz);
        int e;
        if (!v || w) return 32'h0;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10 || sz != 3'd4) return 32'h0;
        if (m_sel == 8'd0 || m_sel == 8'd2) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'd1) return {8'h0, 8'(N - 1), 8'h0, VER};
        if (m_sel < 8'h10) return 32'h0;
        e = (int'(m_sel) - 16) / 2;
        if (e >= N) return 32'h0;
        return m_sel[0] ? m_ent[e][63:32] : m_ent[e][31:0];
    endfunction

    task automatic mreset();
        for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_sel = 0; m_id = 0; m_resc = 0; m_resc_idx = 0; m_eoi = 0; m_eoi_vec = 0;
    endtask

    task automatic mstep(input logic v, input logic w, input logic [7:0] a, input logic [2:0] sz,
                         input logic [31:0] d, input logic [N-1:0] s, input logic [N-1:0] c,
                         input logic [N-1:0] ds);
        bit wr = v && w;
        m_resc = 0;
        m_eoi  = 0;
        for (int i = 0; i < N; i++) begin
            if (s[i]) m_ent[i][14] = 1'b1;
            else if (c[i]) m_ent[i][14] = 1'b0;
            m_ent[i][12] = ds[i];
        end
        if (wr && a == 8'h10 && sz == 3'd4) begin
            if (m_sel == 8'd0) m_id = d[27:24];
            else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < N) begin
                int e = (int'(m_sel) - 16) / 2;
                logic b12 = m_ent[e][12];
                logic b14 = m_ent[e][14];
                if (m_sel[0]) m_ent[e][63:32] = d;
                else m_ent[e][31:0] = d;
                m_ent[e][12] = b12;
                m_ent[e][14] = m_ent[e][15] ? b14 : 1'b0;
                m_resc = 1;
                m_resc_idx = e;
            end
        end
        if (wr && a == 8'h00) m_sel = d[7:0];
        if (wr && a == 8'h40 && sz == 3'd4 && VER == 8'h20) begin
            m_eoi = 1;
            m_eoi_vec = d[7:0];
        end
    endtask

    task automatic compare_state(input string tag);
        for (int i = 0; i < N; i++)
            chk(tag, $sformatf("entry %0d", i), tbl_flat[i*64 +: 64], m_ent[i]);
        chk(tag, "rescan_pulse", 64'(rescan_pulse), 64'(m_resc));
        if (m_resc) chk(tag, "rescan_idx", 64'(rescan_idx), 64'(m_resc_idx));
        chk(tag, "eoi_pulse", 64'(eoi_pulse), 64'(m_eoi));
        if (m_eoi) chk(tag, "eoi_vec", 64'(eoi_vec), 64'(m_eoi_vec));
    endtask

    // One bus cycle with dispatcher inputs; starts and ends at a falling edge.
    task automatic cyc(input string tag, input logic v, input logic w, input logic [7:0] a,
                       input logic [2:0] sz, input logic [31:0] d,
                       input logic [N-1:0] s = '0, input logic [N-1:0] c = '0,
                       input logic [N-1:0] ds = '0);
        req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        hw_rirr_set = s; hw_rirr_clr = c; hw_dstat = ds;
        #1;
        chk(tag, "rd_data", 64'(rd_data), 64'(mread(v, w, a, sz)));
        @(posedge clk);
        mstep(v, w, a, sz, d, s, c, ds);
        @(negedge clk);
        compare_state(tag);
    endtask

    task automatic wr32(input string tag, input logic [7:0] a, input logic [31:0] d);
        cyc(tag, 1, 1, a, 3'd4, d);
    endtask
    task automatic rd32(input string tag, input logic [7:0] a);
        cyc(tag, 1, 0, a, 3'd4, 32'h0);
    endtask
    task automatic win_wr(input string tag, input logic [7:0] idx, input logic [31:0] d);
        wr32(tag, 8'h00, {24'h0, idx});
        wr32(tag, 8'h10, d);
    endtask
    task automatic win_rd(input string tag, input logic [7:0] idx);
        wr32(tag, 8'h00, {24'h0, idx});
        rd32(tag, 8'h10);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mreset();
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_state("R12 reset state");
        cyc("R12 idle read zero", 0, 0, 8'h10, 3'd4, 0);
        rd32("R12 index after reset", 8'h00);

        cyc("R2 index byte write", 1, 1, 8'h00, 3'd1, 32'hFFFF_FF05);
        rd32("R2 index readback", 8'h00);

        win_wr("R3 ID write", 8'h00, 32'hFA00_0000);
        win_rd("R3 ID read", 8'h00);
        win_rd("R3 alias read", 8'h02);
        win_wr("R3 alias write ignored", 8'h02, 32'h0500_0000);
        win_rd("R3 ID after alias write", 8'h00);

        win_rd("R4 revision read", 8'h01);
        win_wr("R4 revision write ignored", 8'h01, 32'hFFFF_FFFF);
        rd32("R4 revision read again", 8'h10);

        win_wr("R5 entry0 low", 8'h10, 32'h0000_A031);
        win_wr("R5 entry0 high", 8'h11, 32'hC300_0000);
        win_rd("R5 entry0 low read", 8'h10);
        win_rd("R5 entry0 high read", 8'h11);
        win_wr("R5 last entry low", 8'(16 + 2 * N - 2), 32'h0001_80EE);
        win_rd("R5 last entry high read", 8'(16 + 2 * N - 1));

        win_wr("R6 past table write", 8'(16 + 2 * N), 32'hFFFF_FFFF);
        rd32("R6 past table read", 8'h10);
        win_rd("R6 gap index read", 8'h05);
        win_wr("R6 gap index write", 8'h0F, 32'h1234_5678);

        win_wr("R7 prep index", 8'h10, 32'h0000_0011);
        cyc("R7 half-word read", 1, 0, 8'h10, 3'd2, 0);
        cyc("R7 byte write ignored", 1, 1, 8'h10, 3'd1, 32'hFFFF_FFFF);
        rd32("R7 entry unchanged", 8'h10);

        wr32("R1 unknown offset write", 8'h20, 32'hFFFF_FFFF);
        rd32("R1 unknown offset read", 8'h20);
        rd32("R1 offset 0x14 read", 8'h14);

        // Entry 3 level-triggered, then the dispatcher raises remote-IRR and delivery status.
        win_wr("R8 entry3 level", 8'h16, 32'h0000_8041);
        cyc("R8 dispatcher sets rirr", 0, 0, 8'h00, 3'd4, 0, N'(1) << 3, '0, N'(1) << 3);
        cyc("R8 write clears RO attempt", 1, 1, 8'h10, 3'd4, 32'h0000_8042, '0, '0, N'(1) << 3);
        win_rd("R8 RO bits kept", 8'h16);
        wr32("R9 prep index", 8'h00, 32'h16);
        cyc("R9 edge write with same-cycle set", 1, 1, 8'h10, 3'd4, 32'h0000_0043, N'(1) << 3, '0, '0);
        cyc("R8 clear rirr", 0, 0, 8'h00, 3'd4, 0, '0, N'(1) << 3, '0);
        cyc("R9 set on edge entry4", 0, 0, 8'h00, 3'd4, 0, N'(1) << 4, '0, '0);
        win_wr("R9 high write keeps edge", 8'h19, 32'h0F00_0000);
        win_wr("R8 level entry5", 8'h1A, 32'h0000_8050);
        cyc("R8 level write with same-cycle set", 1, 1, 8'h10, 3'd4, 32'h0000_8051, N'(1) << 5, '0, '0);

        win_wr("R10 rescan entry 7", 8'h1E, 32'h0000_0070);

        wr32("R11 eoi write", 8'h40, 32'h0000_0137);
        cyc("R11 eoi short write ignored", 1, 1, 8'h40, 3'd2, 32'h55);
        rd32("R11 eoi read zero", 8'h40);

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] a;
            logic [2:0] sz;
            logic [31:0] d;
            int pick = int'($urandom_range(0, 9));
            a  = (pick < 4) ? 8'h00 : (pick < 8) ? 8'h10 : (pick == 8) ? 8'h40 : 8'($urandom);
            sz = ($urandom_range(0, 5) == 0) ? 3'd2 : 3'd4;
            d  = $urandom;
            if (a == 8'h00 && d[7]) d[7:0] = 8'(16 + $urandom_range(0, 2 * N + 3));
            cyc("R5 R8 R9 R10 random", 1'($urandom_range(0, 3) != 0), 1'($urandom),
                a, sz, d, N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
                N'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule